// File: doc/BRIEF.md
# Instruction prefix and opcode-map parser

This block sits at the front of a 64-bit-mode instruction decoder. It takes instruction bytes one per cycle over a valid/ready handshake. For each instruction it reads every byte up to and including the main opcode byte, then stops. It handles these kinds of front-end byte:

- the three mandatory SIMD prefixes;
- the operand-width/register-extension prefix, whose upper nibble is 0100;
- the two-byte and three-byte vector escapes (first bytes 0xC5 and 0xC4);
- the alternate three-byte vector escape (first byte 0x8F);
- the 0x0F-based escapes that select a legacy opcode map.

Everything the block learns is folded into one normalised record. The register-extension bits come out with the same polarity on every path. The vector-escape prefix field is reported in the same code space as a real mandatory prefix.

The record comes out on registered outputs as a one-cycle pulse. During that pulse cycle the parser drops `in_ready`, then returns to idle for the next instruction. The 0x0F 0x0F sequence carries its real opcode as a trailing byte. The parser flags that case and does not fetch that byte.

A 0x8F byte is ambiguous: it can start the alternate escape or be a plain opcode. The parser resolves this from the low five bits of the byte that follows. When it decides the 0x8F is a plain opcode, it returns that following byte on a spill output so the next stage can use it.

Top module: `pfx_opmap_parser`

## Requirements
- R1: A synchronous active-high reset, asserted at any point, clears all gathered prefix state and any partly parsed escape. While reset is held and in the first cycle after it, `rec_valid` is 0 and `in_ready` is 1. The next single byte 0x90 then gives a map-0 record with class 0 and W/R/X/B all 0.
- R2: Escape bytes select the opcode map. An opcode with no escape is map 0. After 0x0F it is map 1. After 0x0F 0x38 it is map 2, and after 0x0F 0x3A it is map 3. On these legacy paths the record has `rec_vreg`=0, `rec_len256`=0 and `rec_vesc`=0.
- R3: A byte of the form 0100wrxb, seen before any escape or opcode, loads W, R, X and B from bits 3, 2, 1 and 0. If several such bytes come in a row, only the last one counts. If there is none, all four bits read 0.
- R4: Bytes 0x66, 0xF3 and 0xF2 set the prefix class to 1, 2 and 3 respectively; 0 means no prefix. If several appear, the last one wins. A class byte that arrives after a width/extension byte discards that earlier byte, so W/R/X/B read 0 unless another width/extension byte follows.
- R5: 0xC4 starts a three-byte vector escape. Payload byte 1 gives R, X and B as the inverses of its bits 7, 6 and 5, and its bits 4..0 give the map. Payload byte 2 gives W from bit 7, `rec_vreg` as the inverse of bits 6..3, L from bit 2, and the class directly from bits 1..0. The next byte is the opcode, and `rec_vesc` is 1.
- R6: 0xC5 starts a two-byte vector escape. Its payload byte gives R as the inverse of bit 7, `rec_vreg` as the inverse of bits 6..3, L from bit 2 and the class from bits 1..0. The record then has X=0, B=0, W=0, map 1 and `rec_vesc`=1, and the next byte is the opcode.
- R7: 0x8F followed by a byte whose bits 4..0 are 8 or more is decoded exactly as in R5.
- R8: 0x8F followed by a byte whose bits 4..0 are below 8 gives an opcode 0x8F in map 0, keeping any prefix class and width/extension bits. It also sets `rec_spill_valid`=1, with that following byte on `rec_spill_byte`.
- R9: The sequence 0x0F 0x0F gives a record with map 1, opcode 0x0F and `rec_sfx`=1. The record is emitted at once, without fetching the trailing byte.
- R10: Each instruction produces exactly one record pulse, one cycle long, in the cycle after its opcode byte is accepted. `in_ready` is 0 only in that cycle. Bytes offered while `in_valid` is 0 have no effect.
- R11: No prefix, width/extension or vector state carries over from one instruction to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_map | output | 5 | Opcode map number |
| rec_opcode | output | 8 | Main opcode byte |
| rec_mpc | output | 2 | Mandatory-prefix class (0 none, 1 0x66, 2 0xF3, 3 0xF2) |
| rec_w | output | 1 | Operand-width bit |
| rec_r | output | 1 | Reg-field extension, true polarity |
| rec_x | output | 1 | Index-field extension, true polarity |
| rec_b | output | 1 | Base/rm-field extension, true polarity |
| rec_vreg | output | 4 | Extra vector register number, true polarity |
| rec_len256 | output | 1 | Vector length bit |
| rec_vesc | output | 1 | Record came through a vector escape |
| rec_sfx | output | 1 | Opcode is a trailing suffix byte (0x0F 0x0F) |
| rec_spill_valid | output | 1 | A byte after 0x8F was consumed as lookahead |
| rec_spill_byte | output | 8 | The consumed lookahead byte |

## Verification
Some properties are checked on every cycle:
- the record strobe lasts one cycle and coincides with the ready gap;
- a legacy record never carries vector fields and never has a map above 3;
- a suffix-opcode record always reads map 1, opcode 0x0F;
- a spill is only reported with opcode 0x8F, map 0 and a lookahead map field below 8.

The bench scenarios are needed for the rest:
- the exact field values;
- the inversion back to true polarity;
- last-wins ordering among width/extension and class bytes;
- a class byte discarding an earlier width/extension byte;
- the 0x8F threshold;
- the isolation between instructions;
- reset in the middle of an instruction.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 5;
  localparam int VREG_W = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t B_OSZ   = 8'h66;
  localparam byte_t B_REP   = 8'hF3;
  localparam byte_t B_REPNE = 8'hF2;
  localparam byte_t B_ESC   = 8'h0F;
  localparam byte_t B_ESC38 = 8'h38;
  localparam byte_t B_ESC3A = 8'h3A;
  localparam byte_t B_V3    = 8'hC4;
  localparam byte_t B_V2    = 8'hC5;
  localparam byte_t B_AV    = 8'h8F;

  localparam logic [1:0] MPC_NONE = 2'd0;
  localparam logic [1:0] MPC_66   = 2'd1;
  localparam logic [1:0] MPC_F3   = 2'd2;
  localparam logic [1:0] MPC_F2   = 2'd3;

  typedef enum logic [2:0] {
    ST_PFX, ST_ESC1, ST_OPC, ST_V3B1, ST_V3B2, ST_V2B1, ST_ACHK, ST_DONE
  } st_e;

  typedef struct packed {
    logic [MAP_W-1:0]  map;
    logic [1:0]        mpc;
    logic              w;
    logic              r;
    logic              x;
    logic              b;
    logic [VREG_W-1:0] vreg;
    logic              len;
    logic              vesc;
  } acc_t;
endpackage

// File: rtl/opf_byte_class.sv
module opf_byte_class
  import opf_pkg::*;
(
  input  byte_t      byte_i,
  output logic       is_mpfx,
  output logic [1:0] mpfx_cls,
  output logic       is_ext,
  output logic       is_esc,
  output logic       is_v3,
  output logic       is_v2,
  output logic       is_av
);
  always_comb begin
    is_mpfx  = 1'b0;
    mpfx_cls = MPC_NONE;
    case (byte_i)
      B_OSZ:   begin is_mpfx = 1'b1; mpfx_cls = MPC_66; end
      B_REP:   begin is_mpfx = 1'b1; mpfx_cls = MPC_F3; end
      B_REPNE: begin is_mpfx = 1'b1; mpfx_cls = MPC_F2; end
      default: ;
    endcase
  end

  assign is_ext = (byte_i[BYTE_W-1:4] == 4'b0100);
  assign is_esc = (byte_i == B_ESC);
  assign is_v3  = (byte_i == B_V3);
  assign is_v2  = (byte_i == B_V2);
  assign is_av  = (byte_i == B_AV);
endmodule

// File: rtl/opf_vesc_fields.sv
module opf_vesc_fields
  import opf_pkg::*;
#(
  parameter int ALT_MIN_MAP = 8
) (
  input  byte_t             byte_i,
  output logic              t_r,
  output logic              t_x,
  output logic              t_b,
  output logic [MAP_W-1:0]  sel_map,
  output logic              is_alt,
  output logic              w_bit,
  output logic [VREG_W-1:0] vreg,
  output logic              len,
  output logic [1:0]        mpc
);
  // first payload byte of the three-byte forms
  assign t_r     = ~byte_i[7];
  assign t_x     = ~byte_i[6];
  assign t_b     = ~byte_i[5];
  assign sel_map = byte_i[MAP_W-1:0];
  assign is_alt  = (int'(byte_i[MAP_W-1:0]) >= ALT_MIN_MAP);
  // second payload byte (three-byte) or only payload byte (two-byte)
  assign w_bit   = byte_i[7];
  assign vreg    = ~byte_i[6:3];
  assign len     = byte_i[2];
  assign mpc     = byte_i[1:0];
endmodule

// File: rtl/pfx_opmap_parser.sv
module pfx_opmap_parser
  import opf_pkg::*;
#(
  parameter int ALT_MIN_MAP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              rec_valid,
  output logic [MAP_W-1:0]  rec_map,
  output logic [BYTE_W-1:0] rec_opcode,
  output logic [1:0]        rec_mpc,
  output logic              rec_w,
  output logic              rec_r,
  output logic              rec_x,
  output logic              rec_b,
  output logic [VREG_W-1:0] rec_vreg,
  output logic              rec_len256,
  output logic              rec_vesc,
  output logic              rec_sfx,
  output logic              rec_spill_valid,
  output logic [BYTE_W-1:0] rec_spill_byte
);
  st_e  state, nxt_state;
  acc_t acc, nxt_acc;

  logic             emit, e_sfx, e_spill;
  logic [MAP_W-1:0] e_map;
  byte_t            e_op;

  logic       c_mpfx, c_ext, c_esc, c_v3, c_v2, c_av;
  logic [1:0] c_cls;

  logic              f_r, f_x, f_b, f_alt, f_w, f_len;
  logic [MAP_W-1:0]  f_map;
  logic [VREG_W-1:0] f_vreg;
  logic [1:0]        f_mpc;

  opf_byte_class u_class (
    .byte_i   (in_data),
    .is_mpfx  (c_mpfx),
    .mpfx_cls (c_cls),
    .is_ext   (c_ext),
    .is_esc   (c_esc),
    .is_v3    (c_v3),
    .is_v2    (c_v2),
    .is_av    (c_av)
  );

  opf_vesc_fields #(.ALT_MIN_MAP(ALT_MIN_MAP)) u_fields (
    .byte_i  (in_data),
    .t_r     (f_r),
    .t_x     (f_x),
    .t_b     (f_b),
    .sel_map (f_map),
    .is_alt  (f_alt),
    .w_bit   (f_w),
    .vreg    (f_vreg),
    .len     (f_len),
    .mpc     (f_mpc)
  );

  assign in_ready = (state != ST_DONE);

  always_comb begin
    nxt_state = state;
    nxt_acc   = acc;
    emit      = 1'b0;
    e_sfx     = 1'b0;
    e_spill   = 1'b0;
    e_map     = acc.map;
    e_op      = in_data;
    if (state == ST_DONE) begin
      nxt_state = ST_PFX;
    end else if (in_valid) begin
      case (state)
        ST_PFX: begin
          if (c_mpfx) begin
            nxt_acc.mpc = c_cls;
            {nxt_acc.w, nxt_acc.r, nxt_acc.x, nxt_acc.b} = 4'b0000;
          end else if (c_ext) begin
            {nxt_acc.w, nxt_acc.r, nxt_acc.x, nxt_acc.b} = in_data[3:0];
          end else if (c_esc) begin
            nxt_state = ST_ESC1;
          end else if (c_v3) begin
            nxt_state = ST_V3B1;
          end else if (c_v2) begin
            nxt_state = ST_V2B1;
          end else if (c_av) begin
            nxt_state = ST_ACHK;
          end else begin
            emit  = 1'b1;
            e_map = MAP_W'(0);
          end
        end
        ST_ESC1: begin
          if (in_data == B_ESC38) begin
            nxt_acc.map = MAP_W'(2);
            nxt_state   = ST_OPC;
          end else if (in_data == B_ESC3A) begin
            nxt_acc.map = MAP_W'(3);
            nxt_state   = ST_OPC;
          end else begin
            emit  = 1'b1;
            e_map = MAP_W'(1);
            e_sfx = (in_data == B_ESC);
          end
        end
        ST_OPC: begin
          emit  = 1'b1;
          e_map = acc.map;
        end
        ST_V3B1, ST_ACHK: begin
          if (state == ST_V3B1 || f_alt) begin
            nxt_acc.r    = f_r;
            nxt_acc.x    = f_x;
            nxt_acc.b    = f_b;
            nxt_acc.map  = f_map;
            nxt_acc.vesc = 1'b1;
            nxt_state    = ST_V3B2;
          end else begin
            emit    = 1'b1;
            e_map   = MAP_W'(0);
            e_op    = B_AV;
            e_spill = 1'b1;
          end
        end
        ST_V3B2: begin
          nxt_acc.w    = f_w;
          nxt_acc.vreg = f_vreg;
          nxt_acc.len  = f_len;
          nxt_acc.mpc  = f_mpc;
          nxt_state    = ST_OPC;
        end
        ST_V2B1: begin
          nxt_acc.r    = f_r;
          nxt_acc.x    = 1'b0;
          nxt_acc.b    = 1'b0;
          nxt_acc.w    = 1'b0;
          nxt_acc.vreg = f_vreg;
          nxt_acc.len  = f_len;
          nxt_acc.mpc  = f_mpc;
          nxt_acc.map  = MAP_W'(1);
          nxt_acc.vesc = 1'b1;
          nxt_state    = ST_OPC;
        end
        default: nxt_state = ST_PFX;
      endcase
      if (emit) begin
        nxt_state = ST_DONE;
        nxt_acc   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_PFX;
      acc             <= '0;
      rec_valid       <= 1'b0;
      rec_map         <= '0;
      rec_opcode      <= '0;
      rec_mpc         <= MPC_NONE;
      rec_w           <= 1'b0;
      rec_r           <= 1'b0;
      rec_x           <= 1'b0;
      rec_b           <= 1'b0;
      rec_vreg        <= '0;
      rec_len256      <= 1'b0;
      rec_vesc        <= 1'b0;
      rec_sfx         <= 1'b0;
      rec_spill_valid <= 1'b0;
      rec_spill_byte  <= '0;
    end else begin
      state     <= nxt_state;
      acc       <= nxt_acc;
      rec_valid <= emit;
      if (emit) begin
        rec_map         <= e_map;
        rec_opcode      <= e_op;
        rec_mpc         <= acc.mpc;
        rec_w           <= acc.w;
        rec_r           <= acc.r;
        rec_x           <= acc.x;
        rec_b           <= acc.b;
        rec_vreg        <= acc.vreg;
        rec_len256      <= acc.len;
        rec_vesc        <= acc.vesc;
        rec_sfx         <= e_sfx;
        rec_spill_valid <= e_spill;
        rec_spill_byte  <= e_spill ? in_data : '0;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!rec_valid && in_ready)); // R1
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) rec_valid |=> !rec_valid); // R10
  AST_READY_GAP: assert property (@(posedge clk) disable iff (rst) rec_valid |-> !in_ready); // R10
  AST_LEGACY_CLEAN: assert property (@(posedge clk) disable iff (rst) (rec_valid && !rec_vesc) |-> (rec_vreg == '0 && !rec_len256 && int'(rec_map) <= 3)); // R2
  AST_SFX_SHAPE: assert property (@(posedge clk) disable iff (rst) (rec_valid && rec_sfx) |-> (rec_map == MAP_W'(1) && rec_opcode == B_ESC && !rec_vesc)); // R9
  AST_SPILL_SHAPE: assert property (@(posedge clk) disable iff (rst) (rec_valid && rec_spill_valid) |-> (rec_opcode == B_AV && rec_map == '0 && int'(rec_spill_byte[MAP_W-1:0]) < ALT_MIN_MAP)); // R8
endmodule

// File: tb/test_pfx_opmap_parser.sv
module test_pfx_opmap_parser;
  localparam int ALT_MIN = 8;

  typedef struct packed {
    logic [4:0] map;
    logic [7:0] op;
    logic [1:0] mpc;
    logic       w, r, x, b;
    logic [3:0] vreg;
    logic       len, vesc, sfx, spv;
    logic [7:0] spb;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, rec_valid, rec_w, rec_r, rec_x, rec_b, rec_len256, rec_vesc, rec_sfx, rec_spill_valid;
  logic [4:0] rec_map;
  logic [7:0] rec_opcode, rec_spill_byte;
  logic [1:0] rec_mpc;
  logic [3:0] rec_vreg;

  always #5 clk = ~clk;

  pfx_opmap_parser i_pfx_opmap_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rec_valid(rec_valid), .rec_map(rec_map), .rec_opcode(rec_opcode), .rec_mpc(rec_mpc),
    .rec_w(rec_w), .rec_r(rec_r), .rec_x(rec_x), .rec_b(rec_b), .rec_vreg(rec_vreg),
    .rec_len256(rec_len256), .rec_vesc(rec_vesc), .rec_sfx(rec_sfx),
    .rec_spill_valid(rec_spill_valid), .rec_spill_byte(rec_spill_byte)
  );

  rec_t got;
  assign got = {rec_map, rec_opcode, rec_mpc, rec_w, rec_r, rec_x, rec_b, rec_vreg,
                rec_len256, rec_vesc, rec_sfx, rec_spill_valid, rec_spill_byte};

  int total = 0;
  int bad = 0;
  logic [7:0] seq [12];

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic is_pre(input logic [7:0] v);
    return (v == 8'h66 || v == 8'hF3 || v == 8'hF2 || v[7:4] == 4'h4);
  endfunction

  function automatic void three(input int i, inout rec_t e);
    e.r = ~seq[i+1][7]; e.x = ~seq[i+1][6]; e.b = ~seq[i+1][5];
    e.map = seq[i+1][4:0];
    e.w = seq[i+2][7]; e.vreg = ~seq[i+2][6:3]; e.len = seq[i+2][2];
    e.mpc = seq[i+2][1:0]; e.vesc = 1'b1; e.op = seq[i+3];
  endfunction

  function automatic void model(output rec_t e, output int n);
    int i = 0;
    logic [1:0] m = 2'd0;
    logic [3:0] wx = 4'd0;
    e = '0;
    while (i < 7 && is_pre(seq[i])) begin
      if (seq[i] == 8'h66) begin m = 2'd1; wx = 4'd0; end
      else if (seq[i] == 8'hF3) begin m = 2'd2; wx = 4'd0; end
      else if (seq[i] == 8'hF2) begin m = 2'd3; wx = 4'd0; end
      else wx = seq[i][3:0];
      i++;
    end
    e.mpc = m;
    {e.w, e.r, e.x, e.b} = wx;
    case (seq[i])
      8'hC5: begin
        e.r = ~seq[i+1][7]; e.x = 1'b0; e.b = 1'b0; e.w = 1'b0;
        e.vreg = ~seq[i+1][6:3]; e.len = seq[i+1][2]; e.mpc = seq[i+1][1:0];
        e.map = 5'd1; e.vesc = 1'b1; e.op = seq[i+2]; n = i + 3;
      end
      8'hC4: begin three(i, e); n = i + 4; end
      8'h8F: begin
        if (int'(seq[i+1][4:0]) >= ALT_MIN) begin three(i, e); n = i + 4; end
        else begin e.op = 8'h8F; e.map = 5'd0; e.spv = 1'b1; e.spb = seq[i+1]; n = i + 2; end
      end
      8'h0F: begin
        if (seq[i+1] == 8'h38) begin e.map = 5'd2; e.op = seq[i+2]; n = i + 3; end
        else if (seq[i+1] == 8'h3A) begin e.map = 5'd3; e.op = seq[i+2]; n = i + 3; end
        else begin
          e.map = 5'd1; e.op = seq[i+1]; e.sfx = (seq[i+1] == 8'h0F); n = i + 2;
        end
      end
      default: begin e.map = 5'd0; e.op = seq[i]; n = i + 1; end
    endcase
  endfunction

  task automatic clear_seq();
    for (int k = 0; k < 12; k++) seq[k] = 8'h90;
  endtask

  // called at a negedge; returns at a negedge
  task automatic run_seq(input string req, input logic gap);
    rec_t e;
    int n;
    model(e, n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data  = seq[k];
      @(posedge clk);
      @(negedge clk);
      if (k < n - 1) begin
        chk(!rec_valid, "R10", "early record", 64'(rec_valid), 64'd0);
        if (gap) begin
          in_valid = 1'b0;
          in_data  = 8'hC4;
          @(negedge clk);
        end
      end
    end
    in_valid = 1'b0;
    chk(rec_valid && !in_ready, "R10", "pulse/ready", {62'd0, rec_valid, in_ready}, 64'd2);
    chk(got == e, req, "record", 64'(got), 64'(e));
    @(negedge clk);
    chk(!rec_valid && in_ready, "R10", "after pulse", {62'd0, rec_valid, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(!rec_valid && in_ready, "R1", "during reset", {62'd0, rec_valid, in_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(!rec_valid && in_ready, "R1", "after reset", {62'd0, rec_valid, in_ready}, 64'd1);

    // R2 R3 R4: class x width/extension x map
    for (int pc = 0; pc < 5; pc++)
      for (int wx = 0; wx < 17; wx++)
        for (int mp = 0; mp < 4; mp++) begin
          int i = 0;
          clear_seq();
          if (pc == 1) seq[i++] = 8'h66;
          if (pc == 2) seq[i++] = 8'hF3;
          if (pc == 3) seq[i++] = 8'hF2;
          if (pc == 4) begin seq[i++] = 8'h66; seq[i++] = 8'hF2; end
          if (wx < 16) seq[i++] = 8'h40 | 8'(wx);
          if (mp > 0) seq[i++] = 8'h0F;
          if (mp == 2) seq[i++] = 8'h38;
          if (mp == 3) seq[i++] = 8'h3A;
          seq[i] = 8'h10 + 8'(wx % 16);
          run_seq("R2 R3 R4", logic'((wx + mp) % 2));
        end

    // R3: last width/extension byte wins
    for (int a = 0; a < 16; a += 5)
      for (int c = 0; c < 16; c += 3) begin
        clear_seq();
        seq[0] = 8'h40 | 8'(a); seq[1] = 8'h40 | 8'(c); seq[2] = 8'h01;
        run_seq("R3", 1'b0);
      end

    // R4: class byte after width/extension discards it
    for (int a = 0; a < 16; a++) begin
      clear_seq();
      seq[0] = 8'h40 | 8'(a); seq[1] = (a % 2) ? 8'hF3 : 8'h66; seq[2] = 8'h0F; seq[3] = 8'h58;
      run_seq("R4", 1'b0);
      clear_seq();
      seq[0] = 8'hF2; seq[1] = 8'h40 | 8'(a); seq[2] = 8'h66; seq[3] = 8'h4F ^ 8'(a); seq[4] = 8'h22;
      run_seq("R4", 1'b0);
    end

    // R2: every possible first byte followed by filler
    for (int f = 0; f < 256; f++) begin
      clear_seq();
      seq[0] = 8'(f);
      run_seq("R2", 1'b0);
    end

    // R6: two-byte vector escape, every payload value
    for (int p = 0; p < 256; p++) begin
      clear_seq();
      if (p % 2) begin
        seq[0] = 8'h66; seq[1] = 8'h4F; seq[2] = 8'hC5; seq[3] = 8'(p); seq[4] = 8'(255 - p);
      end else begin
        seq[0] = 8'hC5; seq[1] = 8'(p); seq[2] = 8'(p ^ 8'h5A);
      end
      run_seq("R6", logic'(p % 3 == 0));
    end

    // R5: three-byte vector escape
    for (int p = 0; p < 256; p++)
      for (int q = 0; q < 16; q++) begin
        clear_seq();
        seq[0] = 8'hC4; seq[1] = 8'(p); seq[2] = 8'(q * 17); seq[3] = 8'(p + q);
        run_seq("R5", 1'b0);
      end

    // R7 R8: 0x8F threshold
    for (int p = 0; p < 256; p++)
      for (int q = 0; q < 2; q++) begin
        clear_seq();
        seq[0] = q ? 8'hF3 : 8'h90; seq[1] = q ? 8'h4B : 8'h90;
        if (!q) begin seq[0] = 8'h8F; seq[1] = 8'(p); seq[2] = 8'hA5; seq[3] = 8'h3C; end
        else begin seq[2] = 8'h8F; seq[3] = 8'(p); seq[4] = 8'h69; seq[5] = 8'hE1; end
        run_seq((int'(p % 32) >= ALT_MIN) ? "R7" : "R8", 1'b0);
      end

    // R9: suffix-opcode escape with width/extension variants
    for (int wx = 0; wx < 17; wx++) begin
      clear_seq();
      if (wx < 16) begin seq[0] = 8'h40 | 8'(wx); seq[1] = 8'h0F; seq[2] = 8'h0F; end
      else begin seq[0] = 8'h0F; seq[1] = 8'h0F; end
      run_seq("R9", 1'b0);
    end

    // R11: a fully decorated instruction followed by a bare opcode
    clear_seq();
    seq[0] = 8'hF2; seq[1] = 8'h4F; seq[2] = 8'h0F; seq[3] = 8'h3A; seq[4] = 8'h0B;
    run_seq("R11", 1'b0);
    clear_seq();
    run_seq("R11", 1'b0);
    clear_seq();
    seq[0] = 8'hC4; seq[1] = 8'h02; seq[2] = 8'h85; seq[3] = 8'h18;
    run_seq("R11", 1'b0);
    clear_seq();
    run_seq("R11", 1'b0);

    // R1: reset in the middle of an instruction
    in_valid = 1'b1; in_data = 8'h66;
    @(posedge clk); @(negedge clk);
    in_data = 8'h4F;
    @(posedge clk); @(negedge clk);
    in_data = 8'hC4;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!rec_valid && in_ready, "R1", "mid reset", {62'd0, rec_valid, in_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    clear_seq();
    run_seq("R1", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule